// File: doc/BRIEF.md
# Serial Memory Command Sequencer

This block sits behind a serial-peripheral byte receiver and runs the command protocol of a small byte-wide nonvolatile memory. The receiver supplies whole bytes together with the level of the active-low chip select. The sequencer treats the first byte of every selection as a command code. For memory commands it then collects a two-byte address and streams data into or out of an internal byte-wide register file. After each data byte the address advances by one, and it wraps at the top of the array. No page buffer and no busy flag are involved, so a write burst can be any length.

The block does not decide write permission. For each write data byte it presents the target address to an external protection unit and commits the byte only when that unit reports the address as writable. It also sends that unit pulses that set and clear write enable, plus status write requests. For a status read it returns the unit's status byte. Transmit bytes for reads go out on a byte-wide output with a one-cycle valid strobe, for the serialiser to shift out.

Top module: `ssq_sequencer`

## Requirements
- R1: After synchronous reset, all output strobes (`tx_valid`, `wel_set`, `wel_clr`, `stat_wr`) are 0 and `chk_addr` is 0.
- R2: A first byte of 0x06 gives exactly one `wel_set` pulse. A first byte of 0x04 gives exactly one `wel_clr` pulse.
- R3: Only the first byte received while `cs_n` is low is decoded as a command. Bytes that follow a command without operands cause no further action. Bytes received while `cs_n` is high are ignored. A new command needs `cs_n` to go high first.
- R4: A first byte that is none of 0x06, 0x04, 0x05, 0x01, 0x03, 0x02 causes every later byte of that selection to be ignored.
- R5: A first byte of 0x05 produces exactly one transmit byte equal to `prot_status`. Later bytes of the selection produce no transmit byte.
- R6: A first byte of 0x01 makes the next byte appear on `stat_wdata` with exactly one `stat_wr` pulse. Later bytes are ignored.
- R7: Commands 0x03 and 0x02 take a two-byte address, high byte first. Only the low AW bits of that 16-bit value select the start location.
- R8: After command 0x02 and its address, each data byte is stored at the current address and the address then advances by one. The address wraps from 2^AW-1 to 0, and there is no limit on burst length.
- R9: During a write burst, `chk_addr` shows the target address of the next data byte. A byte arriving while `prot_wr_ok` is 0 is not stored, but the address still advances.
- R10: After command 0x03 and its address, the block emits the byte at the start address. Each further received byte causes the byte at the next address (wrapping) to be emitted. Received data bytes during a read are never stored.
- R11: Raising `cs_n` ends any operation. If the selection carried a 0x02 or 0x01 command, `wel_clr` pulses once when `cs_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select level, active low, already synchronised |
| rx_valid | input | 1 | One-cycle strobe: a complete received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| prot_status | input | 8 | Status byte supplied by the protection unit |
| prot_wr_ok | input | 1 | Protection unit: address on `chk_addr` may be written |
| chk_addr | output | AW | Current data address, offered for the write permission check |
| tx_valid | output | 1 | One-cycle strobe: `tx_data` holds the next byte to shift out |
| tx_data | output | 8 | Transmit byte |
| wel_set | output | 1 | Pulse: set write enable |
| wel_clr | output | 1 | Pulse: clear write enable |
| stat_wr | output | 1 | Pulse: write `stat_wdata` into the status register |
| stat_wdata | output | 8 | Status byte to be written |

## Verification
The bench builds the block with AW = 6, so the array holds 64 bytes and ten of the sixteen address bits are discarded. With that setting, bursts of a few dozen bytes cross the wrap point in both directions, a nonzero high address byte shows that the discarded bits really are ignored, and the whole array can be filled and then checked against a model. A moving writable limit in the bench's protection model splits write bursts into stored and skipped bytes. The default AW = 11 only widens the counter and array without adding any new path.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_BYTES = 2;
  localparam int ADDR_FULL_W = ADDR_BYTES * BYTE_W;

  localparam logic [BYTE_W-1:0] OPC_WEN_SET = 8'h06;
  localparam logic [BYTE_W-1:0] OPC_WEN_CLR = 8'h04;
  localparam logic [BYTE_W-1:0] OPC_STAT_RD = 8'h05;
  localparam logic [BYTE_W-1:0] OPC_STAT_WR = 8'h01;
  localparam logic [BYTE_W-1:0] OPC_MEM_RD  = 8'h03;
  localparam logic [BYTE_W-1:0] OPC_MEM_WR  = 8'h02;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_SWR,
    ST_SINK
  } seq_state_e;
endpackage

// File: rtl/ssq_mem.sv
module ssq_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // single write port, registered read port: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
  import ssq_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              prot_wr_ok,
  output logic [AW-1:0]     addr_q,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              fetch_req,
  output logic              stat_load,
  output logic              wel_set,
  output logic              wel_clr,
  output logic              stat_wr,
  output logic [BYTE_W-1:0] stat_wdata
);
  localparam logic [AW-1:0] ADDR_STEP = {{(AW-1){1'b0}}, 1'b1};

  seq_state_e              state;
  logic [BYTE_W-1:0]       hi_q;
  logic                    rd_op;
  logic                    wr_armed;
  logic [ADDR_FULL_W-1:0]  addr_full;
  logic                    take;

  assign addr_full = {hi_q, rx_data};
  assign take      = rx_valid && !cs_n;

  // write port: data byte in write phase, gated by the protection unit
  always_comb begin
    mem_we    = take && (state == ST_WDAT) && prot_wr_ok;
    mem_wdata = rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_OPC;
      hi_q       <= '0;
      rd_op      <= 1'b0;
      wr_armed   <= 1'b0;
      addr_q     <= '0;
      fetch_req  <= 1'b0;
      stat_load  <= 1'b0;
      wel_set    <= 1'b0;
      wel_clr    <= 1'b0;
      stat_wr    <= 1'b0;
      stat_wdata <= '0;
    end else begin
      fetch_req <= 1'b0;
      stat_load <= 1'b0;
      wel_set   <= 1'b0;
      wel_clr   <= 1'b0;
      stat_wr   <= 1'b0;
      // a fetch has just sampled the array: move to the next location
      if (fetch_req) addr_q <= addr_q + ADDR_STEP;
      if (cs_n) begin
        state <= ST_OPC;
        if (wr_armed) begin
          wel_clr  <= 1'b1;
          wr_armed <= 1'b0;
        end
      end else if (rx_valid) begin
        unique case (state)
          ST_OPC: begin
            unique case (rx_data)
              OPC_WEN_SET: begin
                wel_set <= 1'b1;
                state   <= ST_SINK;
              end
              OPC_WEN_CLR: begin
                wel_clr <= 1'b1;
                state   <= ST_SINK;
              end
              OPC_STAT_RD: begin
                stat_load <= 1'b1;
                state     <= ST_SINK;
              end
              OPC_STAT_WR: begin
                wr_armed <= 1'b1;
                state    <= ST_SWR;
              end
              OPC_MEM_RD: begin
                rd_op <= 1'b1;
                state <= ST_AHI;
              end
              OPC_MEM_WR: begin
                rd_op    <= 1'b0;
                wr_armed <= 1'b1;
                state    <= ST_AHI;
              end
              default: state <= ST_SINK;
            endcase
          end
          ST_AHI: begin
            hi_q  <= rx_data;
            state <= ST_ALO;
          end
          ST_ALO: begin
            addr_q <= addr_full[AW-1:0];
            if (rd_op) begin
              fetch_req <= 1'b1;
              state     <= ST_RDAT;
            end else begin
              state <= ST_WDAT;
            end
          end
          ST_WDAT: addr_q <= addr_q + ADDR_STEP;
          ST_RDAT: fetch_req <= 1'b1;
          ST_SWR: begin
            stat_wr    <= 1'b1;
            stat_wdata <= rx_data;
            state      <= ST_SINK;
          end
          default: state <= ST_SINK;
        endcase
      end
    end
  end

  p_deselect_idle_r11: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (state == ST_OPC));

  p_wdata_advance_r8: assert property (@(posedge clk) disable iff (rst)
    (take && state == ST_WDAT) |=> (addr_q == $past(addr_q) + ADDR_STEP));

  p_single_request_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wel_set, wel_clr, stat_wr, stat_load}));

  p_sink_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SINK) |=> (!wel_set && !stat_wr && !fetch_req && !stat_load));
endmodule

// File: rtl/ssq_txstage.sv
module ssq_txstage
  import ssq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_req,
  input  logic              stat_load,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic [BYTE_W-1:0] prot_status,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);
  logic fetch_d;

  // fetch_req cycle: array samples the address; next cycle: data is ready
  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_d  <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      fetch_d  <= fetch_req;
      tx_valid <= 1'b0;
      if (fetch_d) begin
        tx_data  <= rd_data;
        tx_valid <= 1'b1;
      end else if (stat_load) begin
        tx_data  <= prot_status;
        tx_valid <= 1'b1;
      end
    end
  end

  p_tx_single_r5: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid);
endmodule

// File: rtl/ssq_sequencer.sv
module ssq_sequencer
  import ssq_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic [BYTE_W-1:0] prot_status,
  input  logic              prot_wr_ok,
  output logic [AW-1:0]     chk_addr,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              wel_set,
  output logic              wel_clr,
  output logic              stat_wr,
  output logic [BYTE_W-1:0] stat_wdata
);
  logic [AW-1:0]     addr_q;
  logic              mem_we;
  logic [BYTE_W-1:0] mem_wdata;
  logic [BYTE_W-1:0] rd_data;
  logic              fetch_req;
  logic              stat_load;

  ssq_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .prot_wr_ok (prot_wr_ok),
    .addr_q     (addr_q),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .fetch_req  (fetch_req),
    .stat_load  (stat_load),
    .wel_set    (wel_set),
    .wel_clr    (wel_clr),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata)
  );

  ssq_mem #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (addr_q),
    .wdata (mem_wdata),
    .raddr (addr_q),
    .rdata (rd_data)
  );

  ssq_txstage u_tx (
    .clk         (clk),
    .rst         (rst),
    .fetch_req   (fetch_req),
    .stat_load   (stat_load),
    .rd_data     (rd_data),
    .prot_status (prot_status),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data)
  );

  assign chk_addr = addr_q;

  // a read burst never drives the write port
  p_read_no_store_r10: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> !mem_we);

  // a skipped byte must not reach the array
  p_guarded_store_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_we) |-> (prot_wr_ok && !cs_n));
endmodule

// File: tb/sim_ssq_sequencer.sv
module sim_ssq_sequencer;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic [7:0] prot_status = 8'h00;
  logic prot_wr_ok;
  logic [AW-1:0] chk_addr;
  logic tx_valid;
  logic [7:0] tx_data;
  logic wel_set, wel_clr, stat_wr;
  logic [7:0] stat_wdata;

  int wr_lim = DEPTH;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int n_wset = 0, n_wclr = 0, n_swr = 0, n_tx = 0;
  logic [7:0] txlog [256];
  logic [7:0] refm [DEPTH];

  always #2.5 clk = ~clk;

  assign prot_wr_ok = (int'(chk_addr) < wr_lim);

  ssq_sequencer #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .prot_status(prot_status), .prot_wr_ok(prot_wr_ok), .chk_addr(chk_addr),
    .tx_valid(tx_valid), .tx_data(tx_data), .wel_set(wel_set), .wel_clr(wel_clr),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wel_set) n_wset++;
      if (wel_clr) n_wclr++;
      if (stat_wr) n_swr++;
      if (tx_valid) begin
        txlog[n_tx & 255] = tx_data;
        n_tx++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_data = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel;
    @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic int wrapa(input int a);
    return a % DEPTH;
  endfunction

  // write burst; the model stores only bytes the protection model allows
  task automatic wr_burst(input int start16, input int n, input int seed_val);
    sel();
    send(8'h02);
    send(8'((start16 >> 8) & 255));
    send(8'(start16 & 255));
    for (int i = 0; i < n; i++) begin
      int a = wrapa(start16 + i);
      logic [7:0] d = 8'((seed_val + i * 37) & 255);
      send(d);
      if (a < wr_lim) refm[a] = d;
    end
    desel();
  endtask

  task automatic rd_burst(input int start16, input int n, input string req);
    int base;
    base = n_tx;
    sel();
    send(8'h03);
    send(8'((start16 >> 8) & 255));
    send(8'(start16 & 255));
    for (int i = 0; i < n; i++) send(8'hEE);
    desel();
    chk(n_tx - base == n + 1, req, n_tx - base, n + 1);
    for (int i = 0; i <= n; i++) begin
      int a = wrapa(start16 + i);
      chk(txlog[(base + i) & 255] == refm[a], req,
          int'(txlog[(base + i) & 255]), int'(refm[a]));
    end
  endtask

  initial begin
    int ws, wc, sw, tb, sa, ln;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!tx_valid && !wel_set && !wel_clr && !stat_wr, "R1", int'({tx_valid, wel_set, wel_clr, stat_wr}), 0);
    chk(chk_addr == '0, "R1", int'(chk_addr), 0);

    // R8: fill whole array from address 0
    wr_lim = DEPTH;
    wc = n_wclr;
    wr_burst(0, DEPTH, 11);
    chk(n_wclr == wc + 1, "R11 wel_clr on deselect after write", n_wclr - wc, 1);
    // R10: read across the wrap, dummy bytes not stored
    rd_burst(DEPTH - 4, 8, "R10");
    rd_burst(0, DEPTH - 1, "R10 full");
    // R8: write across wrap
    wr_burst(DEPTH - 2, 4, 200);
    rd_burst(DEPTH - 3, 6, "R8 wrap");

    // R2: enable set / clear
    ws = n_wset; wc = n_wclr;
    sel(); send(8'h06); desel();
    chk(n_wset == ws + 1, "R2 set", n_wset - ws, 1);
    sel(); send(8'h04); desel();
    chk(n_wclr == wc + 1, "R2 clr", n_wclr - wc, 1);
    // R3: trailing bytes after a no-operand command
    ws = n_wset; wc = n_wclr; tb = n_tx;
    sel(); send(8'h06); send(8'h06); send(8'h04); send(8'h05); desel();
    chk(n_wset == ws + 1 && n_wclr == wc && n_tx == tb, "R3", n_wset - ws, 1);
    // R3: bytes while deselected
    ws = n_wset;
    send(8'h06);
    repeat (3) @(negedge clk);
    chk(n_wset == ws, "R3 deselected", n_wset - ws, 0);

    // R4: unknown command
    ws = n_wset; wc = n_wclr; sw = n_swr; tb = n_tx;
    sel(); send(8'hFF); send(8'h06); send(8'h01); send(8'h05); desel();
    chk(n_wset == ws && n_wclr == wc && n_swr == sw && n_tx == tb, "R4",
        (n_wset - ws) + (n_wclr - wc) + (n_swr - sw) + (n_tx - tb), 0);
    sel(); send(8'h06); desel();
    chk(n_wset == ws + 1, "R3 new select", n_wset - ws, 1);

    // R5: status read
    prot_status = 8'hA5;
    tb = n_tx;
    sel(); send(8'h05); send(8'h00); send(8'h00); desel();
    chk(n_tx == tb + 1, "R5 count", n_tx - tb, 1);
    chk(txlog[tb & 255] == 8'hA5, "R5 value", int'(txlog[tb & 255]), 8'hA5);

    // R6: status write
    sw = n_swr; wc = n_wclr;
    sel(); send(8'h01); send(8'h8C); send(8'h33); desel();
    chk(n_swr == sw + 1, "R6 count", n_swr - sw, 1);
    chk(stat_wdata == 8'h8C, "R6 value", int'(stat_wdata), 8'h8C);
    chk(n_wclr == wc + 1, "R11 after status write", n_wclr - wc, 1);

    // R9: protection skips bytes but address advances
    wr_lim = 32;
    sel(); send(8'h02); send(8'h00); send(8'd30);
    chk(chk_addr == 6'd30, "R9 addr", int'(chk_addr), 30);
    for (int i = 0; i < 4; i++) begin
      if (30 + i < wr_lim) refm[30 + i] = 8'(8'h60 + i);
      send(8'(8'h60 + i));
    end
    chk(chk_addr == 6'd34, "R9 advance", int'(chk_addr), 34);
    desel();
    rd_burst(28, 7, "R9");
    wr_lim = DEPTH;

    // R7: upper address bits ignored
    wr_burst(16'hAB05, 2, 77);
    rd_burst(16'h0005, 1, "R7");
    rd_burst(16'hFFC5, 1, "R7 high bits");

    // R11: raising select mid-burst ends it
    sel(); send(8'h02); send(8'h00); send(8'd10); send(8'h5A); refm[10] = 8'h5A;
    desel();
    ws = n_wset;
    sel(); send(8'h06); desel();
    chk(n_wset == ws + 1, "R11 fresh command", n_wset - ws, 1);
    rd_burst(9, 2, "R11");

    // random mix
    for (int k = 0; k < 40; k++) begin
      sa = int'($urandom() & 32'hFFFF);
      ln = 1 + int'($urandom() % 70);
      if ($urandom() % 2 == 0) begin
        wr_lim = int'($urandom() % (DEPTH + 1));
        wr_burst(sa, ln, int'($urandom() & 255));
      end else begin
        rd_burst(sa, ln, "R10 random");
      end
    end
    wr_lim = DEPTH;
    rd_burst(0, DEPTH - 1, "R8 final");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog ALL act=timeout exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule